// File: doc/BRIEF.md
# Shared Memory Bus Arbiter for DMA and CPU

This block decides who owns a shared 16-bit memory data bus: a 16-bit processor, or a DMA engine that moves words from DRAM into on-chip peripheral registers. While no DMA is pending, the processor reaches memory through two byte-lane tri-state buffers. The peripheral register-select bus follows the processor's low address bits, so peripheral registers look like ordinary memory locations. The processor's data acknowledge arrives one cycle after its access begins.

DMA requests are sampled only on the falling edge of a color clock, which reaches the block as a one-cycle strobe. Once a request is taken, the block raises the bus request and the DMA address enable together. It shuts both processor buffers and withholds the processor acknowledge, so a processor access in flight simply stalls. It then runs a fixed word sequence. The 18-bit DRAM address goes out as two 9-bit halves, upper half first, each with its own strobe. At the same time the register-select bus carries the destination register, which the engine drives. The fetched word is then written unchanged to that register. A refresh cycle runs the same address sequence but writes no register. The bus is released, or the next word started, on a later color-clock falling edge.

Top module: `shared_bus_arbiter`

## Requirements
- R1: During reset, dbr, dae, dramHighStb, dramLowStb, regWrite, regDriveEn and cpuDtack are low, and dramAddr is zero.
- R2: dbr changes only at a clock edge where cckFall is high. It rises at such an edge when dmaReq is high. Once a word has completed, it falls at the first such edge that sees dmaReq low.
- R3: dae is high exactly when dbr is high. While dae is high, bufLaneEn is all zero and memWrEn is low.
- R4: In the first cycle of each DMA word, dramHighStb is high and dramAddr carries bits [17:9] of the DMA address, captured at the edge the word started. At most one of dramHighStb, dramLowStb and regWrite is high in any cycle.
- R5: In the second cycle, dramLowStb is high and dramAddr carries address bits [8:0]. The memory word on memRdData is sampled at the end of this cycle. dramLowStb never appears without dramHighStb in the cycle before.
- R6: In the third cycle of a non-refresh word, regWrite is high and regWrData equals the sampled 16-bit word, all bits unchanged.
- R7: While dae is high, regDriveEn is high, and during the strobes of a word regSel carries the captured destination register address. While dae is low, regDriveEn is low.
- R8: A word requested with dmaRefresh high produces both address strobes but no regWrite.
- R9: While dae is low, regSel equals cpuAddrLo. bufLaneEn[l] equals cpuAs AND cpuByteEn[l], where lane 1 is bits [15:8] and lane 0 is bits [7:0]. cpuRdData lane l carries memRdData lane l when that lane is enabled and cpuRw is 1 (read), and is 0 otherwise. memWrEn equals cpuAs AND NOT cpuRw. memWrData lane l carries cpuWrData lane l when that lane is enabled, and is 0 otherwise.
- R10: cpuDtack is high only when cpuAs is high, dae is low, and both conditions also held in the previous cycle. It is never high while dae is high. An access stalled by DMA receives cpuDtack in the second cycle after dae falls.
- R11: If dmaReq is still high at the first cckFall edge after a word, the next word starts at that edge without dbr dropping, and it uses freshly captured addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| cckFall | input | 1 | One-cycle strobe marking a color-clock falling edge |
| dmaReq | input | 1 | DMA engine wants the bus |
| dmaRefresh | input | 1 | Requested word is a refresh cycle (no register write) |
| dmaMemAddr | input | 18 | DRAM word address from the DMA engine |
| dmaRegAddr | input | 8 | Destination register address from the DMA engine |
| cpuAs | input | 1 | Processor access in progress |
| cpuRw | input | 1 | Processor direction, 1 = read |
| cpuByteEn | input | 2 | Processor byte-lane enables, bit 1 = upper byte |
| cpuAddrLo | input | 8 | Processor low address bits |
| cpuWrData | input | 16 | Processor write data |
| memRdData | input | 16 | Data present on the shared memory bus |
| dbr | output | 1 | Bus request line, changes only on color-clock falls |
| dae | output | 1 | DMA address enable, fences the processor side |
| dramAddr | output | 9 | Multiplexed DRAM address |
| dramHighStb | output | 1 | Upper address half valid |
| dramLowStb | output | 1 | Lower address half valid |
| regSel | output | 8 | Peripheral register-select bus |
| regDriveEn | output | 1 | DMA engine drives the register-select bus |
| regWrData | output | 16 | Word delivered to the selected register |
| regWrite | output | 1 | Register write strobe |
| bufLaneEn | output | 2 | Processor byte-lane buffer enables |
| cpuRdData | output | 16 | Read data passed to the processor |
| memWrData | output | 16 | Processor write data passed to memory |
| memWrEn | output | 1 | Processor write onto the shared bus |
| cpuDtack | output | 1 | Processor data acknowledge |

## Verification
A wrong sequencer state is visible at the ports within one cycle. Either a strobe comes out of order, a buffer lane is enabled while dae is high, or dbr moves on an edge with no color-clock fall. A corrupted address or data capture register shows up at the next half strobe or register write of that same word, as a wrong DRAM half, a wrong register address or a wrong data bit. A stale acknowledge qualifier shows up as cpuDtack arriving one cycle early after a stall, or appearing during DMA.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HIGH,
    ST_LOW,
    ST_XFER,
    ST_HOLD
  } arbState_t;

  typedef struct packed {
    logic capAddr;
    logic selHigh;
    logic selLow;
    logic capData;
    logic wordWrite;
    logic dmaOwn;
  } ctlStrobe_t;

endpackage

// File: rtl/arb_control.sv
module arb_control
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cckFall,
  input  logic       dmaReq,
  output ctlStrobe_t strobe,
  output logic       dbr
);

  arbState_t state, nextState;
  logic      dbrQ;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (cckFall && dmaReq) nextState = ST_HIGH;
      ST_HIGH: nextState = ST_LOW;
      ST_LOW:  nextState = ST_XFER;
      ST_XFER: nextState = ST_HOLD;
      ST_HOLD: if (cckFall) nextState = dmaReq ? ST_HIGH : ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      dbrQ  <= 1'b0;
    end else begin
      state <= nextState;
      dbrQ  <= (nextState != ST_IDLE);
    end
  end

  always_comb begin
    strobe.capAddr   = (nextState == ST_HIGH);
    strobe.selHigh   = (state == ST_HIGH);
    strobe.selLow    = (state == ST_LOW);
    strobe.capData   = (state == ST_LOW);
    strobe.wordWrite = (state == ST_XFER);
    strobe.dmaOwn    = (state != ST_IDLE);
  end

  assign dbr = dbrQ;

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int REG_W  = 8,
  parameter int DATA_W = 16,
  parameter int HALF_W = (ADDR_W + 1) / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              dmaRefresh,
  input  logic [ADDR_W-1:0] dmaMemAddr,
  input  logic [REG_W-1:0]  dmaRegAddr,
  input  logic [REG_W-1:0]  cpuAddrLo,
  input  logic [DATA_W-1:0] memRdData,
  output logic [HALF_W-1:0] dramAddr,
  output logic              dramHighStb,
  output logic              dramLowStb,
  output logic [REG_W-1:0]  regSel,
  output logic              regDriveEn,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrite
);

  localparam int LOW_W = ADDR_W / 2;

  logic [ADDR_W-1:0] addrQ;
  logic [REG_W-1:0]  regQ;
  logic              refreshQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      regQ     <= '0;
      refreshQ <= 1'b0;
      dataQ    <= '0;
    end else begin
      if (strobe.capAddr) begin
        addrQ    <= dmaMemAddr;
        regQ     <= dmaRegAddr;
        refreshQ <= dmaRefresh;
      end
      if (strobe.capData) dataQ <= memRdData;
    end
  end

  always_comb begin
    if (strobe.selHigh)     dramAddr = addrQ[ADDR_W-1:LOW_W];
    else if (strobe.selLow) dramAddr = HALF_W'(addrQ[LOW_W-1:0]);
    else                    dramAddr = '0;
  end

  assign dramHighStb = strobe.selHigh;
  assign dramLowStb  = strobe.selLow;
  assign regSel      = strobe.dmaOwn ? regQ : cpuAddrLo;
  assign regDriveEn  = strobe.dmaOwn;
  assign regWrite    = strobe.wordWrite && !refreshQ;
  assign regWrData   = regWrite ? dataQ : '0;

endmodule

// File: rtl/arb_cpu_gate.sv
module arb_cpu_gate #(
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dmaOwn,
  input  logic              cpuAs,
  input  logic              cpuRw,
  input  logic [LANES-1:0]  cpuByteEn,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [LANES-1:0]  bufLaneEn,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWrEn,
  output logic              cpuDtack
);

  logic cpuOpen;
  logic seenQ;

  assign cpuOpen = cpuAs && !dmaOwn;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign bufLaneEn[l]          = cpuOpen && cpuByteEn[l];
    assign cpuRdData[l*8 +: 8]   = (bufLaneEn[l] && cpuRw)  ? memRdData[l*8 +: 8] : 8'h00;
    assign memWrData[l*8 +: 8]   = bufLaneEn[l] ? cpuWrData[l*8 +: 8] : 8'h00;
  end

  assign memWrEn = cpuOpen && !cpuRw;

  always_ff @(posedge clk) begin
    if (!rstN) seenQ <= 1'b0;
    else       seenQ <= cpuOpen;
  end

  assign cpuDtack = cpuOpen && seenQ;

endmodule

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter
  import arb_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int REG_W  = 8,
  parameter int DATA_W = 16,
  localparam int HALF_W = (ADDR_W + 1) / 2,
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cckFall,
  input  logic              dmaReq,
  input  logic              dmaRefresh,
  input  logic [ADDR_W-1:0] dmaMemAddr,
  input  logic [REG_W-1:0]  dmaRegAddr,
  input  logic              cpuAs,
  input  logic              cpuRw,
  input  logic [LANES-1:0]  cpuByteEn,
  input  logic [REG_W-1:0]  cpuAddrLo,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              dbr,
  output logic              dae,
  output logic [HALF_W-1:0] dramAddr,
  output logic              dramHighStb,
  output logic              dramLowStb,
  output logic [REG_W-1:0]  regSel,
  output logic              regDriveEn,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrite,
  output logic [LANES-1:0]  bufLaneEn,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWrEn,
  output logic              cpuDtack
);

  ctlStrobe_t strobe;

  arb_control u_control (
    .clk     (clk),
    .rstN    (rstN),
    .cckFall (cckFall),
    .dmaReq  (dmaReq),
    .strobe  (strobe),
    .dbr     (dbr)
  );

  arb_datapath #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .DATA_W (DATA_W),
    .HALF_W (HALF_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .dmaRefresh  (dmaRefresh),
    .dmaMemAddr  (dmaMemAddr),
    .dmaRegAddr  (dmaRegAddr),
    .cpuAddrLo   (cpuAddrLo),
    .memRdData   (memRdData),
    .dramAddr    (dramAddr),
    .dramHighStb (dramHighStb),
    .dramLowStb  (dramLowStb),
    .regSel      (regSel),
    .regDriveEn  (regDriveEn),
    .regWrData   (regWrData),
    .regWrite    (regWrite)
  );

  arb_cpu_gate #(
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_cpu_gate (
    .clk       (clk),
    .rstN      (rstN),
    .dmaOwn    (strobe.dmaOwn),
    .cpuAs     (cpuAs),
    .cpuRw     (cpuRw),
    .cpuByteEn (cpuByteEn),
    .cpuWrData (cpuWrData),
    .memRdData (memRdData),
    .bufLaneEn (bufLaneEn),
    .cpuRdData (cpuRdData),
    .memWrData (memWrData),
    .memWrEn   (memWrEn),
    .cpuDtack  (cpuDtack)
  );

  assign dae = strobe.dmaOwn;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             cckFall,
  input logic             dbr,
  input logic             dae,
  input logic             dramHighStb,
  input logic             dramLowStb,
  input logic             regWrite,
  input logic             regDriveEn,
  input logic [LANES-1:0] bufLaneEn,
  input logic             memWrEn,
  input logic             cpuDtack
);

  p_dbr_on_cck_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dbr != $past(dbr)) |-> $past(cckFall));

  p_fence_r3: assert property (@(posedge clk) disable iff (!rstN)
    dae |-> (bufLaneEn == '0) && !memWrEn);

  p_request_enable_r3: assert property (@(posedge clk) disable iff (!rstN)
    dbr |-> dae);

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dramHighStb, dramLowStb, regWrite}));

  p_half_order_r5: assert property (@(posedge clk) disable iff (!rstN)
    dramLowStb |-> $past(dramHighStb));

  p_word_after_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |-> $past(dramLowStb) && dae);

  p_engine_drives_r7: assert property (@(posedge clk) disable iff (!rstN)
    dramHighStb |-> regDriveEn && dae);

  p_no_ack_dma_r10: assert property (@(posedge clk) disable iff (!rstN)
    dae |-> !cpuDtack);

  p_ack_gap_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dae) |-> !cpuDtack);

endmodule

bind shared_bus_arbiter arb_checker #(.LANES(LANES)) u_arb_checker (
  .clk         (clk),
  .rstN        (rstN),
  .cckFall     (cckFall),
  .dbr         (dbr),
  .dae         (dae),
  .dramHighStb (dramHighStb),
  .dramLowStb  (dramLowStb),
  .regWrite    (regWrite),
  .regDriveEn  (regDriveEn),
  .bufLaneEn   (bufLaneEn),
  .memWrEn     (memWrEn),
  .cpuDtack    (cpuDtack)
);

// File: tb/test_shared_bus_arbiter.sv
`timescale 1ns/1ps
module test_shared_bus_arbiter;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cckFall;
  logic        dmaReq;
  logic        dmaRefresh;
  logic [17:0] dmaMemAddr;
  logic [7:0]  dmaRegAddr;
  logic        cpuAs;
  logic        cpuRw;
  logic [1:0]  cpuByteEn;
  logic [7:0]  cpuAddrLo;
  logic [15:0] cpuWrData;
  logic [15:0] memRdData;
  logic        dbr;
  logic        dae;
  logic [8:0]  dramAddr;
  logic        dramHighStb;
  logic        dramLowStb;
  logic [7:0]  regSel;
  logic        regDriveEn;
  logic [15:0] regWrData;
  logic        regWrite;
  logic [1:0]  bufLaneEn;
  logic [15:0] cpuRdData;
  logic [15:0] memWrData;
  logic        memWrEn;
  logic        cpuDtack;

  shared_bus_arbiter i_shared_bus_arbiter (
    .clk(clk), .rstN(rstN), .cckFall(cckFall), .dmaReq(dmaReq),
    .dmaRefresh(dmaRefresh), .dmaMemAddr(dmaMemAddr), .dmaRegAddr(dmaRegAddr),
    .cpuAs(cpuAs), .cpuRw(cpuRw), .cpuByteEn(cpuByteEn), .cpuAddrLo(cpuAddrLo),
    .cpuWrData(cpuWrData), .memRdData(memRdData), .dbr(dbr), .dae(dae),
    .dramAddr(dramAddr), .dramHighStb(dramHighStb), .dramLowStb(dramLowStb),
    .regSel(regSel), .regDriveEn(regDriveEn), .regWrData(regWrData),
    .regWrite(regWrite), .bufLaneEn(bufLaneEn), .cpuRdData(cpuRdData),
    .memWrData(memWrData), .memWrEn(memWrEn), .cpuDtack(cpuDtack)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;
  bit monOn   = 0;
  bit done    = 0;

  logic [17:0] expRow;
  logic [7:0]  expReg;
  logic [15:0] expData;
  bit          expRefr;
  int words = 0, writesExp = 0, highSeen = 0, writeSeen = 0, dbrLowCnt = 0;
  bit prevDbr = 0, prevHigh = 0;
  bit chainPend = 0;
  int lowMark = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  // color-clock fall strobe, one cycle in four
  initial begin
    int cnt = 0;
    cckFall = 1'b0;
    forever begin
      @(negedge clk);
      cnt++;
      cckFall = (cnt % 4 == 3);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
      summary();
      $finish;
    end
  end

  // port monitor, sampled 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (monOn) begin
      chk(dae == dbr, "R3 dae", dae, dbr);
      if (dae) chk(bufLaneEn == 2'b00 && !memWrEn, "R3 fence", {bufLaneEn, memWrEn}, 0);
      if (dbr != prevDbr) chk(cckFall, "R2 dbr edge", cckFall, 1);
      chk(regDriveEn == dae, "R7 drive", regDriveEn, dae);
      if (!dae) chk(regSel == cpuAddrLo, "R9 regSel", regSel, cpuAddrLo);
      if (dae) chk(!cpuDtack, "R10 no ack in dma", cpuDtack, 0);
      if (dramHighStb) begin
        highSeen++;
        chk(dramAddr == expRow[17:9], "R4 high half", dramAddr, expRow[17:9]);
        chk(regSel == expReg, "R7 dest", regSel, expReg);
      end
      if (dramLowStb) begin
        chk(prevHigh, "R5 order", prevHigh, 1);
        chk(dramAddr == expRow[8:0], "R5 low half", dramAddr, expRow[8:0]);
      end
      if (regWrite) begin
        writeSeen++;
        chk(!expRefr, "R8 refresh write", regWrite, 0);
        chk(regWrData == expData, "R6 word", regWrData, expData);
        chk(regSel == expReg, "R7 dest at write", regSel, expReg);
      end
      if (!dbr) dbrLowCnt++;
      prevDbr  = dbr;
      prevHigh = dramHighStb;
    end
  end

  task automatic doDma(input logic [17:0] row, input logic [7:0] rg,
                       input logic [15:0] dat, input bit refr, input bit keep);
    @(negedge clk);
    dmaMemAddr = row; dmaRegAddr = rg; dmaRefresh = refr; memRdData = dat;
    expRow = row; expReg = rg; expData = dat; expRefr = refr;
    cpuAddrLo = ~rg;
    dmaReq = 1'b1;
    words++;
    if (!refr) writesExp++;
    do begin @(posedge clk); #1; end while (!dramLowStb);
    if (chainPend) begin
      chk(dbrLowCnt == lowMark, "R11 back-to-back", dbrLowCnt, lowMark);
      chainPend = 0;
    end
    @(posedge clk); #1;
    if (keep) begin
      chainPend = 1;
      lowMark = dbrLowCnt;
    end else begin
      @(negedge clk);
      dmaReq = 1'b0;
      do begin @(posedge clk); #1; end while (dbr);
    end
  endtask

  initial begin
    rstN = 0; dmaReq = 0; dmaRefresh = 0; dmaMemAddr = '0; dmaRegAddr = '0;
    cpuAs = 0; cpuRw = 1; cpuByteEn = 0; cpuAddrLo = 8'h3C; cpuWrData = '0; memRdData = '0;
    expRow = '0; expReg = '0; expData = '0; expRefr = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(!dbr && !dae, "R1 request", {dbr, dae}, 0);
    chk(!dramHighStb && !dramLowStb && dramAddr == 9'd0, "R1 dram", {dramHighStb, dramLowStb, dramAddr}, 0);
    chk(!regWrite && !regDriveEn, "R1 reg", {regWrite, regDriveEn}, 0);
    chk(!cpuDtack, "R1 dtack", cpuDtack, 0);
    @(negedge clk);
    rstN = 1;
    monOn = 1;

    // R9 R10 processor sweep over every low address
    for (int a = 0; a < 256; a++) begin
      logic [15:0] mem, wr, rdExp, wrExp;
      logic [1:0]  be;
      logic        rw;
      @(negedge clk);
      be  = a[2:1];
      rw  = a[0];
      mem = 16'(a * 16'h0123) ^ 16'h5A3C;
      wr  = ~mem;
      cpuAddrLo = 8'(a); cpuAs = 1; cpuRw = rw; cpuByteEn = be;
      memRdData = mem; cpuWrData = wr;
      for (int l = 0; l < 2; l++) begin
        rdExp[l*8 +: 8] = (rw && be[l]) ? mem[l*8 +: 8] : 8'h00;
        wrExp[l*8 +: 8] = be[l] ? wr[l*8 +: 8] : 8'h00;
      end
      #1;
      chk(regSel == 8'(a), "R9 regSel follows cpu", regSel, a);
      chk(bufLaneEn == be, "R9 lanes", bufLaneEn, be);
      chk(cpuRdData == rdExp, "R9 read lanes", cpuRdData, rdExp);
      chk(memWrData == wrExp, "R9 write lanes", memWrData, wrExp);
      chk(memWrEn == !rw, "R9 write enable", memWrEn, !rw);
      chk(!cpuDtack, "R10 first cycle", cpuDtack, 0);
      @(posedge clk); #1;
      chk(cpuDtack, "R10 second cycle", cpuDtack, 1);
      @(negedge clk);
      cpuAs = 0;
    end

    // R4..R8 R11 DMA word sweep
    for (int i = 0; i < 256; i++) begin
      logic [17:0] row;
      logic [15:0] dat;
      row = 18'(i * 32'h2F1B + 32'h155);
      if (i < 18) row = 18'(1 << i);
      dat = 16'(i * 16'h9E37) ^ 16'hA5A5;
      doDma(row, 8'(i), dat, (i % 8 == 7), (i % 5 == 2) && (i != 255));
    end

    // R10 stalled processor access
    @(negedge clk);
    cpuAs = 1; cpuRw = 1; cpuByteEn = 2'b11; cpuAddrLo = 8'h11;
    @(posedge clk); #1;
    chk(cpuDtack, "R10 before stall", cpuDtack, 1);
    doDma(18'h2AAAA, 8'hE0, 16'hC3A5, 0, 0);
    chk(!cpuDtack, "R10 first cycle after dma", cpuDtack, 0);
    @(posedge clk); #1;
    chk(cpuDtack, "R10 resumed ack", cpuDtack, 1);
    @(negedge clk);
    cpuAs = 0;
    repeat (4) @(posedge clk);
    #1;
    chk(highSeen == words, "R4 words started", highSeen, words);
    chk(writeSeen == writesExp, "R8 register writes", writeSeen, writesExp);
    done = 1;
    summary();
    $finish;
  end

endmodule